// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block turns a system clock into the bit-level timing of an I2C controller. An 8-bit prescaler cuts the clock into ticks, and programmable tick counts set every phase of the bus: SCL low and high, START setup and hold, STOP setup, data setup and hold, and the release time before a repeated START. The block drives SCL itself (an open-drain "pull low" request). It tells a separate byte engine, through single-cycle strobes, when to change SDA, when to sample SDA, and when to make the SDA edges that form START and STOP conditions.

A caller issues one operation at a time: START, one data BIT, STOP or a repeated START. It pulses `op_go` while `busy` is low, and it gets a one-cycle `op_done` in the last cycle of the operation. Two complete timing sets, one for fast mode and one for high-speed mode, sit side by side on the inputs, and `hs_mode` picks between them. The data-hold count is shared by both sets. During any phase in which SCL is released, the sampled line is watched: while another device holds SCL low, the phase does not advance. This supports clock stretching.

A data bit lasts (div+1) × (t_low + t_high + 2) clock cycles. Adding the external filter and fixed overheads gives the full SCL period, input_clock / f_SCL = (div+1)(t_low + t_high + 2) + 8 + 2 × filter, where filter is a 3-bit count. The prescaler ranges from 0 to 255, and t_low + t_high must lie between 2 and 510.

Top module: `i2c_scl_timer`

## Requirements
- R1: After synchronous reset, SCL is released (`scl_low`=0), `busy`=0, and `op_done` and all four strobes are 0.
- R2: Every phase is counted in ticks of div+1 clock cycles. div is bits 23:16 of the selected word 3. The prescaler restarts at the beginning of each operation.
- R3: A BIT operation (op code 1) holds SCL low for L ticks and then releases it for t_high+1 ticks. L = max(t_low, data_hold + data_setup + 1) + 1. t_low is bits 15:8 and t_high is bits 7:0 of word 2, and data_setup is bits 31:24 of word 2.
- R4: `chg_strb` fires in the last cycle of tick data_hold+1 of the low phase. data_hold is the 8-bit `hold_cnt` input. `smp_strb` fires in the last cycle of the first counted tick of the high phase. At most one of `chg_strb`, `smp_strb`, `sda_fall`, `sda_rise` is high in any cycle.
- R5: A START (op code 0) releases SCL. `sda_fall` fires at the end of start_setup+1 ticks. SCL stays released for start_hold+1 more ticks and is then pulled low as the operation completes. start_setup is bits 31:24 and start_hold is bits 23:16 of word 1.
- R6: A STOP (op code 2) runs the low phase of R3, releases SCL for stop_setup+1 ticks, and then fires `sda_rise` together with `op_done`. SCL then stays released. stop_setup is bits 15:8 of word 1.
- R7: A repeated START (op code 3) runs the low phase of R3 and releases SCL for sr_release+1 ticks. It then fires `sda_fall`, holds start_hold+1 ticks, and pulls SCL low as it completes. sr_release is bits 7:0 of word 3.
- R8: In any phase with SCL released, a cycle with `scl_in` low does not advance the phase, and the tick in progress restarts.
- R9: `hs_mode`=1 selects the three high-speed words and `hs_mode`=0 selects the three fast-mode words. `hold_cnt` applies to both.
- R10: `op_go` while `busy` is high is ignored and does not change the running operation.
- R11: `op_done` is high for exactly one cycle, the last cycle of the operation. `busy` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| op_go | input | 1 | Start an operation (accepted when idle) |
| op_code | input | 2 | 0 START, 1 BIT, 2 STOP, 3 repeated START |
| hs_mode | input | 1 | Select high-speed timing set |
| fs_word1 | input | 32 | Fast set: START setup, START hold, STOP setup |
| fs_word2 | input | 32 | Fast set: data setup, SCL low, SCL high |
| fs_word3 | input | 32 | Fast set: prescaler, repeated-start release |
| hs_word1 | input | 32 | High-speed set, same layout as fs_word1 |
| hs_word2 | input | 32 | High-speed set, same layout as fs_word2 |
| hs_word3 | input | 32 | High-speed set, same layout as fs_word3 |
| hold_cnt | input | 8 | Data hold ticks, shared by both sets |
| scl_in | input | 1 | Synchronised level of the SCL line |
| scl_low | output | 1 | Pull SCL low when 1, release when 0 |
| busy | output | 1 | An operation is in progress |
| op_done | output | 1 | Last cycle of the operation |
| chg_strb | output | 1 | Byte engine may change SDA |
| smp_strb | output | 1 | Byte engine samples SDA |
| sda_fall | output | 1 | Drive SDA low now (START edge) |
| sda_rise | output | 1 | Release SDA now (STOP edge) |

## Verification
The bench measures the cycle of every strobe and the length of the low phase against counts computed from the programmed fields. An off-by-one in a phase limit or in the prescaler reload therefore shows up as a strobe one tick early or late. A separate case lengthens the low phase through a large data-setup count; a design that used only t_low would release SCL too soon. A stretch case holds SCL low at the start of the high phase; a design that kept counting would sample and finish early. Further cases cover an `op_go` issued mid-operation with the STOP code, which would leave SCL released if it were taken, and a swap to the high-speed set with different values, which exposes a stuck or reversed mode select.

// File: rtl/i2c_tgen_pkg.sv
package i2c_tgen_pkg;

    localparam int FLD_W  = 8;
    localparam int WORD_W = 32;
    localparam int CNT_W  = FLD_W + 1;

    typedef enum logic [1:0] {
        OP_START   = 2'd0,
        OP_BIT     = 2'd1,
        OP_STOP    = 2'd2,
        OP_RESTART = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE_HI,
        S_IDLE_LO,
        S_ST_SU,
        S_ST_HD,
        S_LOW,
        S_HIGH,
        S_STOP_SU,
        S_SR_REL
    } seq_e;

    typedef struct packed {
        logic [FLD_W-1:0] div;
        logic [FLD_W-1:0] start_su;
        logic [FLD_W-1:0] start_hd;
        logic [FLD_W-1:0] stop_su;
        logic [FLD_W-1:0] data_su;
        logic [FLD_W-1:0] data_hd;
        logic [FLD_W-1:0] t_low;
        logic [FLD_W-1:0] t_high;
        logic [FLD_W-1:0] sr_rel;
    } timing_t;

    function automatic timing_t unpack_set(
        input logic [WORD_W-1:0] w1,
        input logic [WORD_W-1:0] w2,
        input logic [WORD_W-1:0] w3,
        input logic [FLD_W-1:0]  hd
    );
        timing_t t;
        t.start_su = w1[31:24];
        t.start_hd = w1[23:16];
        t.stop_su  = w1[15:8];
        t.data_su  = w2[31:24];
        t.t_low    = w2[15:8];
        t.t_high   = w2[7:0];
        t.div      = w3[23:16];
        t.sr_rel   = w3[7:0];
        t.data_hd  = hd;
        return t;
    endfunction

    function automatic logic is_released(input seq_e s);
        return (s == S_ST_SU) || (s == S_ST_HD) || (s == S_HIGH) ||
               (s == S_STOP_SU) || (s == S_SR_REL);
    endfunction

endpackage

// File: rtl/i2c_tgen_select.sv
module i2c_tgen_select
    import i2c_tgen_pkg::*;
(
    input  logic              hs_mode,
    input  logic [WORD_W-1:0] fs_word1,
    input  logic [WORD_W-1:0] fs_word2,
    input  logic [WORD_W-1:0] fs_word3,
    input  logic [WORD_W-1:0] hs_word1,
    input  logic [WORD_W-1:0] hs_word2,
    input  logic [WORD_W-1:0] hs_word3,
    input  logic [FLD_W-1:0]  hold_cnt,
    output timing_t           tm
);
    timing_t fs_set;
    timing_t hs_set;

    always_comb begin
        fs_set = unpack_set(fs_word1, fs_word2, fs_word3, hold_cnt);
        hs_set = unpack_set(hs_word1, hs_word2, hs_word3, hold_cnt);
        tm     = hs_mode ? hs_set : fs_set;
    end
endmodule

// File: rtl/i2c_tgen_prescale.sv
module i2c_tgen_prescale
    import i2c_tgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic [FLD_W-1:0] div_i,
    output logic             tick_o
);
    logic [FLD_W-1:0] pcnt;

    assign tick_o = (pcnt == div_i) && !clr_i;

    always_ff @(posedge clk) begin
        if (rst || clr_i || tick_o) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

    // R2: a tick is followed by a full prescaler period before the next one
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
        (tick_o && div_i != '0) |=> !tick_o);
endmodule

// File: rtl/i2c_tgen_seq.sv
module i2c_tgen_seq
    import i2c_tgen_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    go_i,
    input  op_e     op_i,
    input  timing_t tm,
    input  logic    tick_i,
    input  logic    scl_in,
    output logic    presc_clr_o,
    output logic    scl_low_o,
    output logic    busy_o,
    output logic    done_o,
    output logic    chg_o,
    output logic    smp_o,
    output logic    fall_o,
    output logic    rise_o
);
    seq_e             st, nxt;
    op_e              op_q;
    logic [CNT_W-1:0] tcnt;
    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] low_min;
    logic             idle, stall, ph_end;

    assign idle        = (st == S_IDLE_HI) || (st == S_IDLE_LO);
    assign stall       = is_released(st) && !scl_in;
    assign presc_clr_o = idle || stall;
    assign low_min     = {1'b0, tm.data_hd} + {1'b0, tm.data_su} + CNT_W'(1);

    always_comb begin
        case (st)
            S_ST_SU:   lim = {1'b0, tm.start_su};
            S_ST_HD:   lim = {1'b0, tm.start_hd};
            S_LOW:     lim = ({1'b0, tm.t_low} >= low_min) ? {1'b0, tm.t_low} : low_min;
            S_HIGH:    lim = {1'b0, tm.t_high};
            S_STOP_SU: lim = {1'b0, tm.stop_su};
            S_SR_REL:  lim = {1'b0, tm.sr_rel};
            default:   lim = '0;
        endcase
    end

    assign ph_end = !idle && tick_i && !stall && (tcnt == lim);

    always_comb begin
        nxt = st;
        case (st)
            S_IDLE_HI, S_IDLE_LO:
                if (go_i) nxt = (op_i == OP_START) ? S_ST_SU : S_LOW;
            S_ST_SU:   if (ph_end) nxt = S_ST_HD;
            S_ST_HD:   if (ph_end) nxt = S_IDLE_LO;
            S_LOW:
                if (ph_end) begin
                    case (op_q)
                        OP_STOP:    nxt = S_STOP_SU;
                        OP_RESTART: nxt = S_SR_REL;
                        default:    nxt = S_HIGH;
                    endcase
                end
            S_HIGH:    if (ph_end) nxt = S_IDLE_LO;
            S_STOP_SU: if (ph_end) nxt = S_IDLE_HI;
            S_SR_REL:  if (ph_end) nxt = S_ST_HD;
            default:   nxt = S_IDLE_HI;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= S_IDLE_HI;
            op_q <= OP_START;
            tcnt <= '0;
        end else begin
            st <= nxt;
            if (idle && go_i) op_q <= op_i;
            if (idle || ph_end) tcnt <= '0;
            else if (tick_i && !stall) tcnt <= tcnt + 1'b1;
        end
    end

    assign scl_low_o = (st == S_IDLE_LO) || (st == S_LOW);
    assign busy_o    = !idle;
    assign chg_o     = (st == S_LOW) && tick_i && (tcnt == {1'b0, tm.data_hd});
    assign smp_o     = (st == S_HIGH) && tick_i && !stall && (tcnt == '0);
    assign fall_o    = ph_end && ((st == S_ST_SU) || (st == S_SR_REL));
    assign rise_o    = ph_end && (st == S_STOP_SU);
    assign done_o    = ph_end && ((st == S_ST_HD) || (st == S_HIGH) || (st == S_STOP_SU));

    // R4: strobes never overlap
    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({chg_o, smp_o, fall_o, rise_o}));
    // R8: a stretched released phase keeps its count and its state
    p_stall_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        (!idle && stall) |=> ($stable(tcnt) && st == $past(st)));
    // R11: done is followed by idle
    p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (busy_o == 1'b0));
    // R6: after the STOP edge SCL stays released
    p_rise_release_r6: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> (!scl_low_o && !busy_o));
    // R10: a request while busy leaves the running operation alone
    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (rst)
        (!idle && go_i) |=> $stable(op_q));
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
    import i2c_tgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_go,
    input  logic [1:0]        op_code,
    input  logic              hs_mode,
    input  logic [WORD_W-1:0] fs_word1,
    input  logic [WORD_W-1:0] fs_word2,
    input  logic [WORD_W-1:0] fs_word3,
    input  logic [WORD_W-1:0] hs_word1,
    input  logic [WORD_W-1:0] hs_word2,
    input  logic [WORD_W-1:0] hs_word3,
    input  logic [FLD_W-1:0]  hold_cnt,
    input  logic              scl_in,
    output logic              scl_low,
    output logic              busy,
    output logic              op_done,
    output logic              chg_strb,
    output logic              smp_strb,
    output logic              sda_fall,
    output logic              sda_rise
);
    timing_t tm;
    logic    tick, presc_clr;

    i2c_tgen_select u_sel (
        .hs_mode  (hs_mode),
        .fs_word1 (fs_word1),
        .fs_word2 (fs_word2),
        .fs_word3 (fs_word3),
        .hs_word1 (hs_word1),
        .hs_word2 (hs_word2),
        .hs_word3 (hs_word3),
        .hold_cnt (hold_cnt),
        .tm       (tm)
    );

    i2c_tgen_prescale u_pre (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (presc_clr),
        .div_i  (tm.div),
        .tick_o (tick)
    );

    i2c_tgen_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .go_i        (op_go),
        .op_i        (op_e'(op_code)),
        .tm          (tm),
        .tick_i      (tick),
        .scl_in      (scl_in),
        .presc_clr_o (presc_clr),
        .scl_low_o   (scl_low),
        .busy_o      (busy),
        .done_o      (op_done),
        .chg_o       (chg_strb),
        .smp_o       (smp_strb),
        .fall_o      (sda_fall),
        .rise_o      (sda_rise)
    );
endmodule

// File: tb/test_i2c_scl_timer.sv
`timescale 1ns/1ps
module test_i2c_scl_timer;

    typedef struct {
        int d, ssu, shd, psu, dsu, tl, th, sr;
    } cfg_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_go = 1'b0;
    logic [1:0]  op_code = 2'd0;
    logic        hs_mode = 1'b0;
    logic [31:0] fs_word1, fs_word2, fs_word3, hs_word1, hs_word2, hs_word3;
    logic [7:0]  hold_cnt;
    logic        ext_low = 1'b0;
    logic        scl_low, busy, op_done, chg_strb, smp_strb, sda_fall, sda_rise;
    logic        scl_in;

    int errors = 0;
    int checks = 0;
    cfg_t fcfg, hcfg;
    int hd;
    int t_chg, t_smp, t_fall, t_rise, t_done, n_low;
    int post_low, post_busy, post_done;

    assign scl_in = !(scl_low || ext_low);

    always #2.5 clk = ~clk;

    i2c_scl_timer i_i2c_scl_timer (
        .clk(clk), .rst(rst), .op_go(op_go), .op_code(op_code), .hs_mode(hs_mode),
        .fs_word1(fs_word1), .fs_word2(fs_word2), .fs_word3(fs_word3),
        .hs_word1(hs_word1), .hs_word2(hs_word2), .hs_word3(hs_word3),
        .hold_cnt(hold_cnt), .scl_in(scl_in), .scl_low(scl_low), .busy(busy),
        .op_done(op_done), .chg_strb(chg_strb), .smp_strb(smp_strb),
        .sda_fall(sda_fall), .sda_rise(sda_rise)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic apply_cfg();
        fs_word1 = {8'(fcfg.ssu), 8'(fcfg.shd), 8'(fcfg.psu), 8'h00};
        fs_word2 = {8'(fcfg.dsu), 8'h00, 8'(fcfg.tl), 8'(fcfg.th)};
        fs_word3 = {8'h00, 8'(fcfg.d), 8'h00, 8'(fcfg.sr)};
        hs_word1 = {8'(hcfg.ssu), 8'(hcfg.shd), 8'(hcfg.psu), 8'h00};
        hs_word2 = {8'(hcfg.dsu), 8'h00, 8'(hcfg.tl), 8'(hcfg.th)};
        hs_word3 = {8'h00, 8'(hcfg.d), 8'h00, 8'(hcfg.sr)};
        hold_cnt = 8'(hd);
    endtask

    function automatic cfg_t cur();
        return hs_mode ? hcfg : fcfg;
    endfunction

    function automatic int low_ticks(input cfg_t c);
        return ((c.tl > hd + c.dsu + 1) ? c.tl : hd + c.dsu + 1) + 1;
    endfunction

    task automatic run_op(input logic [1:0] code, input int stall_k, input int stray_at);
        int r;
        bit fin;
        t_chg = -1; t_smp = -1; t_fall = -1; t_rise = -1; t_done = -1;
        n_low = 0; r = 0; fin = 0;
        @(negedge clk);
        op_go = 1'b1; op_code = code; ext_low = (stall_k > 0);
        @(posedge clk);
        for (int n = 0; n < 20000; n++) begin
            @(negedge clk);
            if (chg_strb && t_chg < 0) t_chg = n;
            if (smp_strb && t_smp < 0) t_smp = n;
            if (sda_fall && t_fall < 0) t_fall = n;
            if (sda_rise && t_rise < 0) t_rise = n;
            if (scl_low) n_low++; else r++;
            if (op_done) begin t_done = n; fin = 1; end
            #1;
            op_go = (n == stray_at);
            if (n == stray_at) op_code = 2'd2;
            if (ext_low && r == stall_k + 1) ext_low = 1'b0;
            if (fin) break;
        end
        op_go = 1'b0; ext_low = 1'b0;
        if (!fin) begin
            errors++; checks++;
            $display("FAIL R11 watchdog: got no done expected done");
        end
        @(negedge clk);
        post_low = scl_low; post_busy = busy; post_done = op_done;
    endtask

    task automatic t_reset();
        chk("R1", "scl_low", scl_low, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "strobes", {op_done, chg_strb, smp_strb, sda_fall, sda_rise}, 0);
    endtask

    task automatic t_start();
        cfg_t c = cur();
        int k = c.d + 1;
        run_op(2'd0, 0, -1);
        chk("R5", "start fall", t_fall, (c.ssu + 1) * k - 1);
        chk("R5", "start done", t_done, (c.ssu + c.shd + 2) * k - 1);
        chk("R5", "start low cycles", n_low, 0);
        chk("R5", "start scl after", post_low, 1);
        chk("R11", "start busy after", post_busy, 0);
    endtask

    task automatic t_bit(input string req, input int stall_k, input int stray_at);
        cfg_t c = cur();
        int k = c.d + 1;
        int l = low_ticks(c);
        run_op(2'd1, stall_k, stray_at);
        chk(req, "bit low cycles", n_low, l * k);
        chk("R4", "bit chg", t_chg, (hd + 1) * k - 1);
        chk(req, "bit smp", t_smp, l * k + stall_k + k - 1);
        chk(req, "bit done", t_done, (l + c.th + 1) * k + stall_k - 1);
        chk("R11", "bit done pulse", post_done, 0);
        chk("R11", "bit busy after", post_busy, 0);
        chk(req, "bit scl after", post_low, 1);
    endtask

    task automatic t_stop();
        cfg_t c = cur();
        int k = c.d + 1;
        int l = low_ticks(c);
        run_op(2'd2, 0, -1);
        chk("R6", "stop low cycles", n_low, l * k);
        chk("R6", "stop rise", t_rise, (l + c.psu + 1) * k - 1);
        chk("R6", "stop done", t_done, (l + c.psu + 1) * k - 1);
        chk("R6", "stop scl after", post_low, 0);
        chk("R11", "stop busy after", post_busy, 0);
    endtask

    task automatic t_restart();
        cfg_t c = cur();
        int k = c.d + 1;
        int l = low_ticks(c);
        run_op(2'd3, 0, -1);
        chk("R7", "restart fall", t_fall, (l + c.sr + 1) * k - 1);
        chk("R7", "restart done", t_done, (l + c.sr + c.shd + 2) * k - 1);
        chk("R7", "restart low cycles", n_low, l * k);
        chk("R7", "restart scl after", post_low, 1);
    endtask

    initial begin
        #(200000 * 5);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        fcfg = '{d:2, ssu:3, shd:2, psu:4, dsu:1, tl:6, th:4, sr:5};
        hcfg = '{d:0, ssu:1, shd:1, psu:1, dsu:0, tl:3, th:2, sr:1};
        hd = 1;
        apply_cfg();
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_start();
        t_bit("R3", 0, -1);
        t_bit("R10", 0, 10);
        t_bit("R8", 5, -1);
        fcfg.dsu = 9;
        apply_cfg();
        t_bit("R3", 0, -1);
        fcfg.dsu = 1;
        apply_cfg();
        t_stop();
        t_start();
        t_restart();
        hs_mode = 1'b1;
        t_bit("R9", 0, -1);
        t_restart();
        t_stop();
        hs_mode = 1'b0;
        fcfg.d = 0;
        apply_cfg();
        t_start();
        t_bit("R2", 0, -1);
        t_stop();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule